// File: doc/BRIEF.md
# Lane-Partitioned Adder with Padding Blanking

This block adds two 32-bit words as one, two or four independent integer lanes, chosen by a 2-bit mode input. It is purely combinational. Each lane is narrower than the slot that holds it, and it sits at the bottom of a power-of-two aligned slot. That alignment lets lanes be taken from and returned to the word with plain wiring, without shifting.

The bits between the top of one lane and the start of the next slot are padding. A blanking mask is derived at elaboration time from the fixed lane layout and selected by the mode. This mask clears padding bits on the operands before the add and on the sum after it. Each lane wraps modulo two to the power of its width, and no carry ever leaves a lane. The block fits between registered pipeline stages of a datapath whose element width changes from context to context.

Because the block holds no state and has no data handshake, no back-pressure rules apply: the sum follows the inputs combinationally.

Top module: `simd_part_adder`

## Requirements
- R1: With lane_mode_i = 2'b00, sum_o[10:0] equals (opa_i[10:0] + opb_i[10:0]) modulo 2^11.
- R2: With lane_mode_i = 2'b01, two 11-bit lanes are produced: sum_o[10:0] from operand bits 10..0, and sum_o[26:16] from operand bits 26..16, each modulo 2^11.
- R3: With lane_mode_i = 2'b10, four 5-bit lanes are produced at bits 4..0, 12..8, 20..16 and 28..24, each equal to the sum of the same operand bits modulo 2^5.
- R4: lane_mode_i = 2'b11 produces the same output as 2'b00 for any operands.
- R5: Every padding bit of sum_o is zero. These are bits 31..11 in mode 2'b00, bits 15..11 and 31..27 in mode 2'b01, and bits 7..5, 15..13, 23..21 and 31..29 in mode 2'b10.
- R6: sum_o[31:29] is zero in every mode.
- R7: A carry out of a lane's top bit is dropped. It neither changes the next lane nor appears in a padding bit, so an all-ones lane plus one gives zero while its neighbours keep their own sums.
- R8: Operand bits at padding positions of the current mode have no effect on sum_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand word |
| opb_i | input | 32 | Second operand word |
| lane_mode_i | input | 2 | Lane split: 00 one lane, 01 two lanes, 10 four lanes, 11 same as 00 |
| sum_o | output | 32 | Lane-wise sum with padding bits cleared |

## Verification
On every input change, the bound checker tests four things: that bits 31..29 are clear, that the single-lane sum and its padding are right in modes 00 and 11, that the upper two-lane result is right together with its padding gap, and that the top four-lane result is right with one inter-lane gap clear. Only the bench's scenarios can show isolation and independence. It checks a lane wrapping without disturbing its neighbour, and it checks that garbage in padding operand bits leaves the sum unchanged; both require comparing two separate stimuli. The bench also checks every lane of every mode against a per-lane reference computed in the bench.

// File: rtl/simd_part_pkg.sv
package simd_part_pkg;

  typedef enum logic [1:0] {
    MODE_ONE  = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_FOUR = 2'b10,
    MODE_ALT  = 2'b11
  } lane_mode_e;

  // Slot size for a mode, as a right shift of the full word width.
  function automatic int slot_shift(input lane_mode_e m);
    case (m)
      MODE_TWO:  return 1;
      MODE_FOUR: return 2;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/simd_lane_map.sv
module simd_lane_map #(
  parameter int WIDTH  = 32,
  parameter int W_ONE  = 11,
  parameter int W_TWO  = 11,
  parameter int W_FOUR = 5
) (
  input  logic [1:0]       mode_i,
  output logic [WIDTH-1:0] keep_o,
  output logic [WIDTH-1:0] start_o
);
  import simd_part_pkg::*;

  localparam int SLOT1 = WIDTH;
  localparam int SLOT2 = WIDTH / 2;
  localparam int SLOT4 = WIDTH / 4;

  lane_mode_e mode;
  assign mode = lane_mode_e'(mode_i);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    // Static layout bits, fixed at elaboration per mode.
    localparam bit K1 = ((i % SLOT1) < W_ONE);
    localparam bit K2 = ((i % SLOT2) < W_TWO);
    localparam bit K4 = ((i % SLOT4) < W_FOUR);
    localparam bit S1 = ((i % SLOT1) == 0);
    localparam bit S2 = ((i % SLOT2) == 0);
    localparam bit S4 = ((i % SLOT4) == 0);

    always_comb begin
      case (mode)
        MODE_TWO: begin
          keep_o[i]  = K2;
          start_o[i] = S2;
        end
        MODE_FOUR: begin
          keep_o[i]  = K4;
          start_o[i] = S4;
        end
        default: begin
          keep_o[i]  = K1;
          start_o[i] = S1;
        end
      endcase
    end
  end

endmodule

// File: rtl/simd_kill_chain.sv
module simd_kill_chain #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [WIDTH-1:0] kill_i,
  output logic [WIDTH-1:0] s_o
);
  logic [WIDTH-1:0] cin;
  logic [WIDTH-1:0] prop;
  logic [WIDTH-1:0] gen;

  assign prop = a_i ^ b_i;
  assign gen  = a_i & b_i;
  assign cin[0] = 1'b0;

  for (genvar i = 1; i < WIDTH; i++) begin : g_carry
    // A lane start refuses the carry from the bit below.
    assign cin[i] = ~kill_i[i] & (gen[i-1] | (prop[i-1] & cin[i-1]));
  end

  assign s_o = prop ^ cin;

endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder #(
  parameter int WIDTH  = 32,
  parameter int W_ONE  = 11,
  parameter int W_TWO  = 11,
  parameter int W_FOUR = 5
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [1:0]       lane_mode_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] keep;
  logic [WIDTH-1:0] lane_start;
  logic [WIDTH-1:0] a_blank;
  logic [WIDTH-1:0] b_blank;
  logic [WIDTH-1:0] raw_sum;

  simd_lane_map #(
    .WIDTH (WIDTH),
    .W_ONE (W_ONE),
    .W_TWO (W_TWO),
    .W_FOUR(W_FOUR)
  ) u_map (
    .mode_i (lane_mode_i),
    .keep_o (keep),
    .start_o(lane_start)
  );

  assign a_blank = opa_i & keep;
  assign b_blank = opb_i & keep;

  simd_kill_chain #(
    .WIDTH(WIDTH)
  ) u_chain (
    .a_i   (a_blank),
    .b_i   (b_blank),
    .kill_i(lane_start),
    .s_o   (raw_sum)
  );

  assign sum_o = raw_sum & keep;

endmodule

// File: rtl/simd_part_adder_chk.sv
module simd_part_adder_chk #(
  parameter int WIDTH  = 32,
  parameter int W_ONE  = 11,
  parameter int W_TWO  = 11,
  parameter int W_FOUR = 5
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [1:0]       lane_mode_i,
  input logic [WIDTH-1:0] sum_o
);
  localparam int HALF = WIDTH / 2;
  localparam int QTR  = WIDTH / 4;
  localparam int TOPQ = 3 * QTR;

  logic [W_ONE-1:0]  one_ref;
  logic [W_TWO-1:0]  two_hi_ref;
  logic [W_FOUR-1:0] four_top_ref;

  always_comb begin
    one_ref      = opa_i[W_ONE-1:0] + opb_i[W_ONE-1:0];
    two_hi_ref   = opa_i[HALF +: W_TWO] + opb_i[HALF +: W_TWO];
    four_top_ref = opa_i[TOPQ +: W_FOUR] + opb_i[TOPQ +: W_FOUR];

    AST_TOP_ZERO: assert (sum_o[WIDTH-1:TOPQ+W_FOUR] == '0); // R6

    if (lane_mode_i == 2'b00 || lane_mode_i == 2'b11) begin
      AST_ONE_LANE: assert (sum_o[W_ONE-1:0] == one_ref && sum_o[WIDTH-1:W_ONE] == '0); // R1
    end

    if (lane_mode_i == 2'b01) begin
      AST_TWO_HIGH: assert (sum_o[HALF +: W_TWO] == two_hi_ref && sum_o[HALF-1:W_TWO] == '0); // R2
    end

    if (lane_mode_i == 2'b10) begin
      AST_FOUR_TOP: assert (sum_o[TOPQ +: W_FOUR] == four_top_ref && sum_o[QTR-1:W_FOUR] == '0); // R3
    end
  end

endmodule

bind simd_part_adder simd_part_adder_chk #(
  .WIDTH (WIDTH),
  .W_ONE (W_ONE),
  .W_TWO (W_TWO),
  .W_FOUR(W_FOUR)
) u_chk (
  .opa_i      (opa_i),
  .opb_i      (opb_i),
  .lane_mode_i(lane_mode_i),
  .sum_o      (sum_o)
);

// File: tb/sim_simd_part_adder.sv
module sim_simd_part_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa;
  logic [31:0] opb;
  logic [1:0]  mode;
  logic [31:0] sum;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  simd_part_adder u0 (
    .opa_i      (opa),
    .opb_i      (opb),
    .lane_mode_i(mode),
    .sum_o      (sum)
  );

  function automatic logic [31:0] ref_sum(input logic [31:0] a, input logic [31:0] b,
                                          input logic [1:0] m);
    int n; int slot; int w;
    logic [31:0] r;
    case (m)
      2'b01:   begin n = 2; slot = 16; w = 11; end
      2'b10:   begin n = 4; slot = 8;  w = 5;  end
      default: begin n = 1; slot = 32; w = 11; end
    endcase
    r = '0;
    for (int l = 0; l < n; l++) begin
      logic [31:0] lane;
      lane = ((a >> (l * slot)) + (b >> (l * slot))) & ((32'd1 << w) - 32'd1);
      r = r | (lane << (l * slot));
    end
    return r;
  endfunction

  function automatic logic [31:0] pad_mask(input logic [1:0] m);
    case (m)
      2'b01:   return 32'hF800_F800;
      2'b10:   return 32'hE0E0_E0E0;
      default: return 32'hFFFF_F800;
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    @(negedge clk);
    opa = a; opb = b; mode = m;
    #1;
  endtask

  task automatic expect_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_case(input string tag, input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] m);
    apply(a, b, m);
    expect_eq(tag, sum, ref_sum(a, b, m));
  endtask

  task automatic t_reset;
    expect_eq("R1 reset zero-operand output", sum, 32'h0);
  endtask

  task automatic t_single;
    run_case("R1 single lane small", 32'h0000_0123, 32'h0000_0045, 2'b00);
    run_case("R1 single lane wrap", 32'h0000_07FF, 32'h0000_0001, 2'b00);
    for (int k = 0; k < 40; k++) run_case("R1 single random", $urandom, $urandom, 2'b00);
  endtask

  task automatic t_dual;
    run_case("R2 dual lanes", 32'h0123_0456, 32'h0011_0022, 2'b01);
    for (int k = 0; k < 40; k++) run_case("R2 dual random", $urandom, $urandom, 2'b01);
  endtask

  task automatic t_quad;
    run_case("R3 quad lanes", 32'h0102_0304, 32'h0405_0607, 2'b10);
    for (int k = 0; k < 40; k++) run_case("R3 quad random", $urandom, $urandom, 2'b10);
  endtask

  task automatic t_alias;
    for (int k = 0; k < 20; k++) begin
      logic [31:0] a; logic [31:0] b; logic [31:0] s0;
      a = $urandom; b = $urandom;
      apply(a, b, 2'b00);
      s0 = sum;
      apply(a, b, 2'b11);
      expect_eq("R4 mode 11 matches 00", sum, s0);
    end
  endtask

  task automatic t_padding;
    for (int m = 0; m < 3; m++) begin
      apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'(m));
      expect_eq("R5 padding outputs zero", sum & pad_mask(2'(m)), 32'h0);
      expect_eq("R6 top three bits zero", sum & 32'hE000_0000, 32'h0);
    end
  endtask

  task automatic t_wrap;
    apply(32'h0000_07FF, 32'h0000_0001, 2'b01);
    expect_eq("R7 dual low lane wraps alone", sum, 32'h0000_0000);
    apply(32'h0005_07FF, 32'h0003_0001, 2'b01);
    expect_eq("R7 dual upper lane unaffected", sum, 32'h0008_0000);
    apply(32'h0101_011F, 32'h0101_0101, 2'b10);
    expect_eq("R7 quad lane0 wrap isolated", sum, 32'h0202_0200);
    apply(32'h1F1F_1F1F, 32'h0101_0101, 2'b10);
    expect_eq("R7 quad all lanes wrap", sum, 32'h0000_0000);
  endtask

  task automatic t_ignore;
    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 10; k++) begin
        logic [31:0] a; logic [31:0] b; logic [31:0] s0;
        a = $urandom & ~pad_mask(2'(m));
        b = $urandom & ~pad_mask(2'(m));
        apply(a, b, 2'(m));
        s0 = sum;
        apply(a | ($urandom & pad_mask(2'(m))), b | ($urandom & pad_mask(2'(m))), 2'(m));
        expect_eq("R8 padding operand bits ignored", sum, s0);
      end
    end
  endtask

  initial begin
    opa = '0; opb = '0; mode = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_dual();
    t_quad();
    t_alias();
    t_padding();
    t_wrap();
    t_ignore();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule